// File: doc/BRIEF.md
# Dual-Port Memory Self-Test Failure Logger

This block sits beside a memory self-test engine and records what went wrong while the engine walks through memories that have either one or two access ports. On every clock the engine presents, for each port, a strobe saying a comparison is valid, a flag saying the read data did not match, and the address being tested. It also presents codes for the memory group and the data slice currently under test. The logger turns these into a compact failure record that software or a test controller reads after the run.

Each port has its own record. The record holds a sticky fail flag, a failure counter that stops at its maximum value, and the address of the first failing access. That first address is frozen once it is taken, but the counter keeps running. One shared pair of group and data-slice codes is also kept. It is captured from the first failing cycle on either port. A single-port memory drives only port 0, so its failures appear only in the port 0 record. A synchronous clear input empties every record so that the next memory can be tested. A small registered read port returns one record word per address.

Top module: `mbist_fail_logger`

## Requirements
- R1: After reset (`rst` high at a clock edge) or after a cycle with `clr` high, every flag, count, first-failure address, captured group code, captured data-slice code and the captured indicator read as zero.
- R2: A port logs a failure only in a cycle where its `cmp_vld_i` bit and its `miscmp_i` bit are both 1. A mismatch with the strobe low changes nothing in that port's record.
- R3: Each port's failure count goes up by one per logged failure and holds at 2^CNT_W-1 (255 by default) instead of wrapping.
- R4: A port's fail flag becomes 1 at its first logged failure and stays 1 until reset or clear. It is 1 exactly when that port's count is nonzero.
- R5: Each port's first-failure address is taken from that port's address input at its first logged failure. Later failures do not change it.
- R6: The group and data-slice codes are captured at the first logged failure on either port, and the captured indicator is set. They are then held until reset or clear.
- R7: When both ports log a failure in the same cycle, both port records update in that cycle, and the shared codes come from that cycle's inputs.
- R8: The read word appears on `rd_data_o` one clock after `rd_addr_i` is presented. The map is as follows. Address 0 is status: bit0 = port 0 flag, bit1 = port 1 flag, bit2 = codes captured. Address 1 is the port 0 count. Address 2 is the port 1 count. Address 3 is the port 0 first address. Address 4 is the port 1 first address. Address 5 carries the group code in bits [GRP_W-1:0] and the data-slice code in bits [GRP_W+DSEL_W-1:GRP_W]. Addresses 6 and 7 read zero. All unused bits read zero.
- R9: When `clr` is high in the same cycle as a failure, the clear wins and nothing from that cycle is recorded.
- R10: Traffic on port 0 alone, as from a single-port memory, leaves the port 1 flag, count and address at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all records |
| cmp_vld_i | input | 2 | Per-port compare-valid strobe (bit0 = port 0) |
| miscmp_i | input | 2 | Per-port mismatch flag (bit0 = port 0) |
| p0_addr_i | input | ADDR_W | Address under test on port 0 |
| p1_addr_i | input | ADDR_W | Address under test on port 1 |
| grp_i | input | GRP_W | Current memory group code |
| dsel_i | input | DSEL_W | Current data-slice code |
| rd_addr_i | input | 3 | Record word select |
| rd_data_o | output | 32 | Registered record word |

## Verification
The bench drives the counter past 255 on port 0. A counter that wraps would read a small value instead of 255, and port 1 would show stray counts if the two ports' records were not kept separate. Directed cycles drive mismatches with the strobe low, change addresses and codes after the first failure, put two-port failures in one cycle, and raise a clear together with a failure. A design that logs without the strobe, overwrites first-failure state, takes the codes from the wrong cycle, or lets a fail beat the clear would show a wrong record word. Random traffic with occasional clears is compared against a bench model after each round.

// File: rtl/mbist_log_pkg.sv
package mbist_log_pkg;
  localparam int NPORT  = 2;
  localparam int RSEL_W = 3;
  localparam int DATA_W = 32;

  typedef enum logic [RSEL_W-1:0] {
    SEL_STAT = 3'd0,
    SEL_CNT0 = 3'd1,
    SEL_CNT1 = 3'd2,
    SEL_ADR0 = 3'd3,
    SEL_ADR1 = 3'd4,
    SEL_CODE = 3'd5
  } rec_sel_e;
endpackage

// File: rtl/mbist_port_rec.sv
module mbist_port_rec #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              flag_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [ADDR_W-1:0] faddr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag_o  <= 1'b0;
      cnt_o   <= '0;
      faddr_o <= '0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
      if (!flag_o) faddr_o <= addr_i;
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/mbist_code_cap.sv
module mbist_code_cap #(
  parameter int GRP_W  = 5,
  parameter int DSEL_W = 2,
  parameter int NPORT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NPORT-1:0]  hit_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [DSEL_W-1:0] dsel_i,
  output logic              cap_o,
  output logic [GRP_W-1:0]  grp_o,
  output logic [DSEL_W-1:0] dsel_o
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cap_o  <= 1'b0;
      grp_o  <= '0;
      dsel_o <= '0;
    end else if ((|hit_i) && !cap_o) begin
      cap_o  <= 1'b1;
      grp_o  <= grp_i;
      dsel_o <= dsel_i;
    end
  end
endmodule

// File: rtl/mbist_rd_mux.sv
module mbist_rd_mux
  import mbist_log_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 5,
  parameter int DSEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [RSEL_W-1:0]            sel_i,
  input  logic [NPORT-1:0]             flag_i,
  input  logic [NPORT-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NPORT-1:0][ADDR_W-1:0] faddr_i,
  input  logic                         cap_i,
  input  logic [GRP_W-1:0]             grp_i,
  input  logic [DSEL_W-1:0]            dsel_i,
  output logic [DATA_W-1:0]            data_o
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (rec_sel_e'(sel_i))
      SEL_STAT: word = DATA_W'({cap_i, flag_i});
      SEL_CNT0: word = DATA_W'(cnt_i[0]);
      SEL_CNT1: word = DATA_W'(cnt_i[1]);
      SEL_ADR0: word = DATA_W'(faddr_i[0]);
      SEL_ADR1: word = DATA_W'(faddr_i[1]);
      SEL_CODE: word = DATA_W'({dsel_i, grp_i});
      default:  word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) data_o <= '0;
    else     data_o <= word;
  end
endmodule

// File: rtl/mbist_fail_logger.sv
module mbist_fail_logger
  import mbist_log_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 5,
  parameter int DSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [1:0]        cmp_vld_i,
  input  logic [1:0]        miscmp_i,
  input  logic [ADDR_W-1:0] p0_addr_i,
  input  logic [ADDR_W-1:0] p1_addr_i,
  input  logic [GRP_W-1:0]  grp_i,
  input  logic [DSEL_W-1:0] dsel_i,
  input  logic [2:0]        rd_addr_i,
  output logic [31:0]       rd_data_o
);
  logic [NPORT-1:0]             hit_w;
  logic [NPORT-1:0][ADDR_W-1:0] addr_w;
  logic [NPORT-1:0]             flag_w;
  logic [NPORT-1:0][CNT_W-1:0]  cnt_w;
  logic [NPORT-1:0][ADDR_W-1:0] faddr_w;
  logic                         cap_w;
  logic [GRP_W-1:0]             grp_w;
  logic [DSEL_W-1:0]            dsel_w;

  assign hit_w     = cmp_vld_i & miscmp_i;
  assign addr_w[0] = p0_addr_i;
  assign addr_w[1] = p1_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mbist_port_rec #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) rec_i (
      .clk(clk), .rst(rst), .clr(clr),
      .hit_i(hit_w[p]), .addr_i(addr_w[p]),
      .flag_o(flag_w[p]), .cnt_o(cnt_w[p]), .faddr_o(faddr_w[p])
    );
  end

  mbist_code_cap #(.GRP_W(GRP_W), .DSEL_W(DSEL_W), .NPORT(NPORT)) code_i (
    .clk(clk), .rst(rst), .clr(clr), .hit_i(hit_w),
    .grp_i(grp_i), .dsel_i(dsel_i),
    .cap_o(cap_w), .grp_o(grp_w), .dsel_o(dsel_w)
  );

  mbist_rd_mux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRP_W(GRP_W), .DSEL_W(DSEL_W)) rd_i (
    .clk(clk), .rst(rst), .sel_i(rd_addr_i),
    .flag_i(flag_w), .cnt_i(cnt_w), .faddr_i(faddr_w),
    .cap_i(cap_w), .grp_i(grp_w), .dsel_i(dsel_w),
    .data_o(rd_data_o)
  );
endmodule

// File: rtl/mbist_fail_logger_chk.sv
module mbist_fail_logger_chk #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8,
  parameter int GRP_W  = 5,
  parameter int DSEL_W = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clr,
  input logic [1:0]             cmp_vld,
  input logic [1:0]             flag,
  input logic [1:0][CNT_W-1:0]  cnt,
  input logic [1:0][ADDR_W-1:0] faddr,
  input logic                   cap,
  input logic [GRP_W-1:0]       grp,
  input logic [DSEL_W-1:0]      dsel
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar p = 0; p < 2; p++) begin : g_chk
    p_no_log_without_valid_r2: assert property (@(posedge clk) disable iff (rst)
      (!clr && !cmp_vld[p]) |=> ($stable(cnt[p]) && $stable(flag[p])));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (!clr && cnt[p] == CNT_MAX) |=> (cnt[p] == CNT_MAX));

    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr && flag[p]) |=> flag[p]);

    p_flag_vs_count_r4: assert property (@(posedge clk) disable iff (rst)
      flag[p] == (cnt[p] != '0));

    p_addr_frozen_r5: assert property (@(posedge clk) disable iff (rst)
      (!clr && flag[p]) |=> $stable(faddr[p]));
  end

  p_codes_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr && cap) |=> ($stable(grp) && $stable(dsel) && cap));

  p_clear_empties_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (flag == 2'b00 && !cap && cnt[0] == '0 && cnt[1] == '0));
endmodule

bind mbist_fail_logger mbist_fail_logger_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRP_W(GRP_W), .DSEL_W(DSEL_W)
) chk_i (
  .clk(clk), .rst(rst), .clr(clr), .cmp_vld(cmp_vld_i),
  .flag(flag_w), .cnt(cnt_w), .faddr(faddr_w),
  .cap(cap_w), .grp(grp_w), .dsel(dsel_w)
);

// File: tb/mbist_fail_logger_tb_top.sv
`timescale 1ns/1ps
module mbist_fail_logger_tb_top;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 8;
  localparam int GRP_W  = 5;
  localparam int DSEL_W = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst, clr;
  logic [1:0]        cmp_vld_i, miscmp_i;
  logic [ADDR_W-1:0] p0_addr_i, p1_addr_i;
  logic [GRP_W-1:0]  grp_i;
  logic [DSEL_W-1:0] dsel_i;
  logic [2:0]        rd_addr_i;
  logic [31:0]       rd_data_o;

  always #10 clk = ~clk;

  mbist_fail_logger #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .GRP_W(GRP_W), .DSEL_W(DSEL_W)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .cmp_vld_i(cmp_vld_i), .miscmp_i(miscmp_i),
    .p0_addr_i(p0_addr_i), .p1_addr_i(p1_addr_i), .grp_i(grp_i), .dsel_i(dsel_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  int checks = 0;
  int errors = 0;

  bit          m_flag [2];
  int          m_cnt  [2];
  int unsigned m_addr [2];
  bit          m_cap;
  int unsigned m_grp, m_dsel;

  function automatic int unsigned sat_inc(int c);
    return (c >= CMAX) ? CMAX : c + 1;
  endfunction

  function automatic logic [31:0] exp_word(int sel);
    case (sel)
      0: return {29'b0, m_cap, m_flag[1], m_flag[0]};
      1: return 32'(m_cnt[0]);
      2: return 32'(m_cnt[1]);
      3: return 32'(m_addr[0]);
      4: return 32'(m_addr[1]);
      5: return 32'((m_dsel << GRP_W) | m_grp);
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_clear();
    for (int p = 0; p < 2; p++) begin
      m_flag[p] = 0; m_cnt[p] = 0; m_addr[p] = 0;
    end
    m_cap = 0; m_grp = 0; m_dsel = 0;
  endtask

  task automatic step(input logic [1:0] v, input logic [1:0] m,
                      input int unsigned a0, input int unsigned a1,
                      input int unsigned g, input int unsigned d, input bit c);
    logic [1:0] hit;
    @(negedge clk);
    cmp_vld_i = v; miscmp_i = m; clr = c;
    p0_addr_i = ADDR_W'(a0); p1_addr_i = ADDR_W'(a1);
    grp_i = GRP_W'(g); dsel_i = DSEL_W'(d);
    hit = v & m;
    if (c) model_clear();
    else begin
      if (hit != 2'b00 && !m_cap) begin
        m_cap = 1; m_grp = g % (1 << GRP_W); m_dsel = d % (1 << DSEL_W);
      end
      for (int p = 0; p < 2; p++) if (hit[p]) begin
        if (!m_flag[p]) m_addr[p] = ((p == 0) ? a0 : a1) % (1 << ADDR_W);
        m_flag[p] = 1;
        m_cnt[p] = sat_inc(m_cnt[p]);
      end
    end
  endtask

  task automatic rd(input int sel, output logic [31:0] data);
    @(negedge clk);
    cmp_vld_i = 2'b00; miscmp_i = 2'b00; clr = 1'b0;
    rd_addr_i = 3'(sel);
    @(posedge clk);
    #1 data = rd_data_o;
  endtask

  task automatic chk_reg(input string tag, input int sel);
    logic [31:0] got, exp;
    exp = exp_word(sel);
    rd(sel, got);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s reg %0d: actual %h expected %h", tag, sel, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int s = 0; s < 8; s++) chk_reg(tag, s);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; clr = 0; cmp_vld_i = 0; miscmp_i = 0; p0_addr_i = 0; p1_addr_i = 0;
    grp_i = 0; dsel_i = 0; rd_addr_i = 0;
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset state, R8: unmapped words zero
    chk_all("R1 reset");

    // R2: mismatch without strobe ignored
    step(2'b00, 2'b11, 5, 6, 3, 1, 0);
    step(2'b10, 2'b01, 7, 8, 4, 2, 0);
    chk_all("R2 no strobe");

    // R5 / R6: first fail captured, later ones do not overwrite
    step(2'b01, 2'b01, 17, 0, 9, 2, 0);
    step(2'b01, 2'b01, 33, 0, 21, 3, 0);
    step(2'b01, 2'b01, 44, 0, 30, 1, 0);
    chk_all("R5 R6 first capture");
    // R10: port 1 untouched
    chk_reg("R10 port1 count", 2);

    // R7: both ports in one cycle after clear
    step(2'b00, 2'b00, 0, 0, 0, 0, 1);
    step(2'b11, 2'b11, 100, 200, 12, 3, 0);
    step(2'b11, 2'b11, 101, 201, 13, 0, 0);
    chk_all("R7 dual fail");

    // R9: clear beats a simultaneous fail
    step(2'b11, 2'b11, 55, 66, 7, 1, 1);
    chk_all("R9 clear priority");

    // R3: saturation on port 0, R4 flag, R10 port 1 empty
    for (int i = 0; i < CMAX + 40; i++) step(2'b01, 2'b01, 300 + i, 0, 5, 1, 0);
    chk_all("R3 saturate");
    step(2'b01, 2'b01, 999, 0, 6, 2, 0);
    chk_reg("R3 hold max", 1);
    chk_reg("R4 flags", 0);

    // R1: clear empties everything
    step(2'b00, 2'b00, 0, 0, 0, 0, 1);
    chk_all("R1 clear");

    // random rounds
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 150; i++) begin
        logic [1:0] v, m;
        v = 2'($urandom_range(0, 3));
        m[0] = ($urandom_range(0, 7) == 0);
        m[1] = ($urandom_range(0, 7) == 0);
        step(v, m, $urandom_range(0, 1023), $urandom_range(0, 1023),
             $urandom_range(0, 31), $urandom_range(0, 3), ($urandom_range(0, 199) == 0));
      end
      chk_all("R8 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule